// File: doc/BRIEF.md
# Byte-Lane Parity Guard

This block sits between a processor's data path and its memory and keeps one even-parity bit for each byte of the data word. During a write it computes a parity bit per byte of the outgoing data and drives those bits toward memory alongside the data. During a read it takes the parity bits that come back from memory, recomputes parity from the returned data, and compares the two.

A mismatch in any enabled byte is reported on an active-low error flag. The flag is registered and lasts one clock. It only informs: nothing in the transfer waits on it, and deciding what to do about an error is left to logic outside the block.

The parity lines are bidirectional at the pad. Here they are split into an output value, an output enable and an input value, and the pad ring joins them into the shared wires. Byte lane `i` is data bits `[8i+7:8i]`. It uses parity bit `i` and byte enable bit `i`.

Top module: `byte_parity_guard`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `err_n` becomes 1, and it stays 1 until a read reports an error.
- R2: While `wr_stb` is 1, each `par_o[i]` is chosen so that byte `i` of `wdata` together with `par_o[i]` holds an even number of ones. This holds for every lane, whatever `be` is.
- R3: `par_oe` is 1 exactly while `wr_stb` is 1. Whenever `wr_stb` is 0, `par_o` is all zeros.
- R4: If at a rising edge `rd_stb` is 1, `wr_stb` is 0, and some lane `i` with `be[i]`=1 has an odd count of ones across byte `i` of `rdata` and `par_i[i]`, then `err_n` is 0 for the following clock cycle.
- R5: `err_n` is low for exactly one cycle per erroring read. It returns to 1 at the next edge unless that edge also samples an erroring read.
- R6: A lane with `be[i]`=0 never causes an error, whatever its data and parity. With `be` all zero, `err_n` stays 1.
- R7: A read in which every enabled lane has even parity leaves `err_n` at 1.
- R8: When `rd_stb` and `wr_stb` are both 1, the cycle is treated as a write: parity is driven and no read check occurs, so `err_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Write cycle in progress |
| rd_stb | input | 1 | Read cycle; data sampled at the rising edge |
| be | input | 4 | Byte enables, one per lane |
| wdata | input | 32 | Outgoing write data |
| rdata | input | 32 | Returned read data |
| par_i | input | 4 | Parity bits received from memory |
| par_o | output | 4 | Generated parity bits for a write |
| par_oe | output | 1 | Parity pad output enable |
| err_n | output | 1 | Registered active-low parity error flag |

## Verification
The bench uses the default build of 32 data bits split into 8-bit lanes, which gives four lanes. At this lane width every byte value is reachable, so each lane is swept through all 256 values on writes. On reads each of those values is tried with both possible parity bits, with its own enable set and again with it cleared. The sweeps therefore cover every single-lane error and every masked case. Targeted sequences add back-to-back erroring reads, a read and a write in the same cycle, and idle cycles between transfers, so the one-cycle width of the flag and the idle state of the drivers are also observed.

// File: rtl/bpg_pkg.sv
// Package: shared transfer classification for the byte-lane parity guard.
// Assumes a write and a read strobe that may, in error, overlap; writes win.
package bpg_pkg;

    typedef enum logic [1:0] {
        XFER_IDLE  = 2'd0,
        XFER_WRITE = 2'd1,
        XFER_READ  = 2'd2
    } xfer_e;

    // Decide the kind of bus cycle from the two strobes, write first.
    function automatic xfer_e classify_xfer(input logic wr, input logic rd);
        if (wr)      return XFER_WRITE;
        else if (rd) return XFER_READ;
        else         return XFER_IDLE;
    endfunction

endpackage

// File: rtl/bpg_lane_parity.sv
// Module: bpg_lane_parity
// Produces the even-parity bit of one lane: the bit that makes the lane plus
// the bit hold an even number of ones. Purely combinational.
module bpg_lane_parity #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] lane_data,
    output logic              lane_par
);

    // XOR of all bits is 1 exactly when the lane has an odd count of ones.
    always_comb begin
        lane_par = ^lane_data;
    end

endmodule

// File: rtl/bpg_gen.sv
// Module: bpg_gen
// Splits a data word into lanes and builds one even-parity bit per lane.
// Assumes DATA_W is a whole multiple of LANE_W. Combinational.
module bpg_gen #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] word,
    output logic [LANES-1:0]  par
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bpg_lane_parity #(
            .LANE_W (LANE_W)
        ) i_lane (
            .lane_data (word[g*LANE_W +: LANE_W]),
            .lane_par  (par[g])
        );
    end

endmodule

// File: rtl/bpg_read_check.sv
// Module: bpg_read_check
// Compares received parity against parity recomputed from read data, masks
// disabled lanes, and registers an active-low one-cycle error flag.
// Assumes rd_en is already qualified (no write in the same cycle).
module bpg_read_check #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] rdata,
    input  logic [LANES-1:0]  par_in,
    output logic              err_n
);

    logic [LANES-1:0] calc_par;
    logic [LANES-1:0] lane_bad;
    logic             any_bad;
    logic             err_n_q;

    bpg_gen #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) i_recalc (
        .word (rdata),
        .par  (calc_par)
    );

    // Flag enabled lanes whose received bit differs from the recomputed one.
    always_comb begin
        lane_bad = (calc_par ^ par_in) & be;
        any_bad  = rd_en & (|lane_bad);
    end

    // Register the flag; it holds for a single cycle per erroring read.
    always_ff @(posedge clk) begin
        if (!rst_n) err_n_q <= 1'b1;
        else        err_n_q <= ~any_bad;
    end

    assign err_n = err_n_q;

endmodule

// File: rtl/byte_parity_guard.sv
// Module: byte_parity_guard (top)
// Generates per-lane even parity on writes and checks it on reads.
// Assumes the pad ring merges par_o/par_oe/par_i into shared parity wires.
// The error flag never holds up a transfer.
module byte_parity_guard
    import bpg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rdata,
    input  logic [LANES-1:0]  par_i,
    output logic [LANES-1:0]  par_o,
    output logic              par_oe,
    output logic              err_n
);

    xfer_e            xfer;
    logic [LANES-1:0] wr_par;
    logic             rd_en;

    // Classify the current cycle from the strobes.
    always_comb begin
        xfer  = classify_xfer(wr_stb, rd_stb);
        rd_en = (xfer == XFER_READ);
    end

    bpg_gen #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) i_wr_gen (
        .word (wdata),
        .par  (wr_par)
    );

    // Drive parity and enable the pad only during a write.
    always_comb begin
        par_oe = (xfer == XFER_WRITE);
        par_o  = par_oe ? wr_par : '0;
    end

    bpg_read_check #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) i_chk (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .be     (be),
        .rdata  (rdata),
        .par_in (par_i),
        .err_n  (err_n)
    );

endmodule

// File: rtl/byte_parity_guard_chk.sv
// Module: byte_parity_guard_chk
// Property checker for byte_parity_guard, attached by bind.
module byte_parity_guard_chk #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic [LANES-1:0]  be,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [LANES-1:0]  par_i,
    input logic [LANES-1:0]  par_o,
    input logic              par_oe,
    input logic              err_n
);

    logic [LANES-1:0] odd_rd;

    // Per-lane odd count over read byte plus received bit, masked by enable.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            odd_rd[k] = be[k] & (^{rdata[k*LANE_W +: LANE_W], par_i[k]});
        end
    end

    // R1: reset sets the flag high.
    a_r1_reset_flag: assert property (@(posedge clk) !rst_n |=> err_n);

    // R2: each driven lane plus its bit has even ones.
    for (genvar g = 0; g < LANES; g++) begin : g_wr
        a_r2_even_lane: assert property (@(posedge clk) disable iff (!rst_n)
            wr_stb |-> !(^{wdata[g*LANE_W +: LANE_W], par_o[g]}));
    end

    // R3: drivers off and parity zero outside writes.
    a_r3_idle_drivers: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> (!par_oe && par_o == '0));

    // R4 and R5: a low flag follows a real read error in the previous cycle.
    a_r4_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |-> ($past(rd_stb) && !$past(wr_stb) && ($past(odd_rd) != '0)));

    // R4: an erroring read drops the flag next cycle.
    a_r4_flag_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && odd_rd != '0) |=> !err_n);

    // R6 and R7: masked or clean reads leave the flag high.
    a_r7_clean_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && odd_rd == '0) |=> err_n);

    // R8: a write in the same cycle suppresses the check.
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> err_n);

endmodule

bind byte_parity_guard byte_parity_guard_chk #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
) i_byte_parity_guard_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .be     (be),
    .wdata  (wdata),
    .rdata  (rdata),
    .par_i  (par_i),
    .par_o  (par_o),
    .par_oe (par_oe),
    .err_n  (err_n)
);

// File: tb/test_byte_parity_guard.sv
`timescale 1ns/1ps
module test_byte_parity_guard;

    localparam int DW = 32;
    localparam int LW = 8;
    localparam int NL = DW / LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic          rd_stb = 1'b0;
    logic [NL-1:0] be = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata = '0;
    logic [NL-1:0] par_i = '0;
    logic [NL-1:0] par_o;
    logic          par_oe;
    logic          err_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    byte_parity_guard #(.DATA_W(DW), .LANE_W(LW)) i_byte_parity_guard (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .be(be),
        .wdata(wdata), .rdata(rdata), .par_i(par_i), .par_o(par_o),
        .par_oe(par_oe), .err_n(err_n)
    );

    // Count of ones in one byte, by arithmetic.
    function automatic int ones8(input logic [7:0] b);
        int c = 0;
        for (int k = 0; k < 8; k++) c += (b >> k) & 1;
        return c;
    endfunction

    // Even-parity bit of every lane of a word.
    function automatic logic [NL-1:0] exp_par(input logic [DW-1:0] w);
        logic [NL-1:0] p;
        for (int l = 0; l < NL; l++) p[l] = logic'(ones8(w[l*8 +: 8]) % 2);
        return p;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One write cycle with combinational parity checks.
    task automatic do_write(input logic [DW-1:0] d, input logic [NL-1:0] b);
        @(negedge clk);
        wr_stb = 1'b1; rd_stb = 1'b0; wdata = d; be = b;
        #1;
        check("R2 parity", {28'd0, par_o}, {28'd0, exp_par(d)});
        check("R3 oe on write", {31'd0, par_oe}, 32'd1);
        @(negedge clk);
        wr_stb = 1'b0;
        #1;
        check("R3 idle drivers", {27'd0, par_oe, par_o}, 32'd0);
    endtask

    // One read followed by an idle cycle; flag checked in both.
    task automatic do_read(input logic [DW-1:0] d, input logic [NL-1:0] p, input logic [NL-1:0] b);
        logic exp_err = 1'b0;
        for (int l = 0; l < NL; l++)
            if (b[l] && ((ones8(d[l*8 +: 8]) + p[l]) % 2 == 1)) exp_err = 1'b1;
        @(negedge clk);
        rd_stb = 1'b1; rdata = d; par_i = p; be = b;
        @(negedge clk);
        rd_stb = 1'b0;
        check(exp_err ? "R4 error flag" : (b == '0 ? "R6 masked" : "R7 clean"),
              {31'd0, err_n}, {31'd0, ~exp_err});
        @(negedge clk);
        check("R5 one cycle", {31'd0, err_n}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        logic [DW-1:0] base;
        repeat (3) @(negedge clk);
        check("R1 reset flag", {31'd0, err_n}, 32'd1);
        check("R3 reset drivers", {27'd0, par_oe, par_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {31'd0, err_n}, 32'd1);

        // R2: every byte value in every lane, other lanes patterned, be cleared.
        for (int l = 0; l < NL; l++)
            for (int v = 0; v < 256; v++)
                do_write((32'h5A3C_96E1 & ~(32'hFF << (8*l))) | (DW'(v) << (8*l)), '0);

        // R4/R6/R7: every byte value and parity bit per lane, enabled and masked.
        for (int l = 0; l < NL; l++)
            for (int v = 0; v < 256; v++)
                for (int pb = 0; pb < 2; pb++) begin
                    logic [NL-1:0] p;
                    base = (32'hC3A5_0F71 & ~(32'hFF << (8*l))) | (DW'(v) << (8*l));
                    p = exp_par(base);
                    p[l] = pb[0];
                    do_read(base, p, '1);
                    do_read(base, p, ~(NL'(1) << l));
                end

        // R6: all lanes wrong, all enables off.
        do_read(32'h0101_0101, 4'h0, 4'h0);

        // R5: two erroring reads back to back, then a clean one.
        @(negedge clk);
        rd_stb = 1'b1; be = '1; rdata = 32'h0000_0001; par_i = 4'h0;
        @(negedge clk);
        check("R5 first err", {31'd0, err_n}, 32'd0);
        rdata = 32'h0300_0000; par_i = 4'h8;
        @(negedge clk);
        check("R5 second err", {31'd0, err_n}, 32'd0);
        rdata = 32'h0000_0000; par_i = 4'h0;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R5 recovers", {31'd0, err_n}, 32'd1);

        // R8: read and write together with bad read parity.
        @(negedge clk);
        wr_stb = 1'b1; rd_stb = 1'b1; be = '1; wdata = 32'h0000_0007;
        rdata = 32'h0000_0001; par_i = 4'h0;
        #1;
        check("R8 oe", {31'd0, par_oe}, 32'd1);
        check("R8 parity", {28'd0, par_o}, {28'd0, exp_par(32'h0000_0007)});
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
        check("R8 no check", {31'd0, err_n}, 32'd1);

        // R1: reset during a pending error clears it.
        @(negedge clk);
        rd_stb = 1'b1; rdata = 32'h1; par_i = 4'h0; be = 4'h1;
        @(negedge clk);
        rd_stb = 1'b0; rst_n = 1'b0;
        check("R4 pre-reset err", {31'd0, err_n}, 32'd0);
        @(negedge clk);
        check("R1 reset clears", {31'd0, err_n}, 32'd1);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule